// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small bus-based 8-bit computer. Every cycle it produces a 16-bit word of control strobes for the datapath: register loads and drives, memory read and write, program-counter increment and jump, instruction and data latching, display, ALU compute and drive, and halt. It holds a 3-bit step counter. A combinational microcode table maps the step, the 5-bit opcode, the zero flag and the carry flag to the control word. The step sits in address bits 2:0, the opcode in bits 7:3, the zero flag in bit 8 and the carry flag in bit 9.

Because the flags are part of the table address, a conditional jump takes one path or the other through the table itself, with no separate branch logic. Each instruction ends with a step-reset bit in its last word, which sends the counter back to step 0 for the next fetch. A halt strobe in the table freezes the sequencer until reset. A separate halt input pauses it for as long as the input is held.

Top module: `ctrl_sequencer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the step is 0 and the control word is 16'h0100, which is the instruction-latch strobe alone.
- R2: The control word bit positions are: 0 load A, 1 drive A, 2 load B, 3 drive B, 4 memory write, 5 memory read, 6 PC increment, 7 PC jump, 8 instruction latch, 9 data-byte drive, 10 display, 11 halt, 12 ALU compute, 13 ALU drive, 14 reserved and always 0, 15 step reset.
- R3: For every opcode and flag value, step 0 drives the instruction latch alone (bit 8) and step 1 drives the PC increment alone (bit 6).
- R4: A word with bit 15 set is the last step of its instruction. On the next cycle the step is 0 and the word is the fetch word 16'h0100.
- R5: Opcodes 1 and 2 (memory to A or B) drive memory read with load A or load B, then step reset. Opcodes 5 and 6 (A or B to memory) drive A or B with memory write, then step reset. Opcode 7 drives A with display, then step reset.
- R6: Opcodes 3 and 4 (literal to A or B) drive the data byte with load A or load B, then the PC increment, then step reset.
- R7: Opcode 8 (jump) drives the data byte with PC jump, then step reset, for any flag value.
- R8: Opcode 9 jumps (data byte plus PC jump, then step reset) only when the zero flag is 1. Opcode 10 does the same only when the carry flag is 1. Otherwise they skip the data byte: PC increment, then step reset.
- R9: Every opcode with bit 4 set is an ALU operation: ALU compute, then ALU drive with load A, then step reset.
- R10: Opcode 0 and the undefined opcodes 11 to 14 drive step reset alone at step 2.
- R11: Opcode 15 drives the halt strobe alone at step 2. From the next cycle until reset, the step is frozen and the word stays 16'h0800, whatever the opcode and flags do.
- R12: While the halt input is 1, the control word is all zero and the step holds. When the input is released, the sequence resumes at the step it paused on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode | input | 5 | Opcode of the current instruction |
| zero_flag | input | 1 | Zero flag from the ALU |
| carry_flag | input | 1 | Carry flag from the ALU |
| halt | input | 1 | Pauses the sequencer and blanks the control word |
| ctrl_word | output | 16 | Control strobes for the current step |

## Verification
The bench runs every opcode under all four flag combinations and follows each sequence until its step-reset word. It then checks that the next word is the fetch word. A table that ignores a flag, or reads the wrong flag, makes the conditional jumps jump or skip wrongly. A step counter that does not clear on step reset runs into the unused steps instead of refetching. After a halt strobe the bench changes the opcode and the flags. A sequencer that only stops decoding, and does not freeze, then emits other strobes. The bench also pauses a literal load halfway with the halt input. A design that keeps counting while paused loses the step, and one that does not blank the word repeats strobes with side effects.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int STEP_W = 3;
  localparam int OP_W   = 5;
  localparam int CW_W   = 16;
  localparam int ADDR_W = STEP_W + OP_W + 2;

  // control word bit positions
  localparam int CB_LDA  = 0;
  localparam int CB_DRA  = 1;
  localparam int CB_LDB  = 2;
  localparam int CB_DRB  = 3;
  localparam int CB_MWR  = 4;
  localparam int CB_MRD  = 5;
  localparam int CB_PINC = 6;
  localparam int CB_PJMP = 7;
  localparam int CB_ILAT = 8;
  localparam int CB_DBYT = 9;
  localparam int CB_DISP = 10;
  localparam int CB_HALT = 11;
  localparam int CB_ACMP = 12;
  localparam int CB_ADRV = 13;
  localparam int CB_RSVD = 14;
  localparam int CB_SRST = 15;

  typedef logic [CW_W-1:0]   cword_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [OP_W-1:0]   op_t;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,
    OP_MLA  = 5'd1,
    OP_MLB  = 5'd2,
    OP_ILA  = 5'd3,
    OP_ILB  = 5'd4,
    OP_SMA  = 5'd5,
    OP_SMB  = 5'd6,
    OP_SHOW = 5'd7,
    OP_JUMP = 5'd8,
    OP_JZER = 5'd9,
    OP_JCAR = 5'd10,
    OP_STOP = 5'd15
  } opc_e;

  function automatic cword_t strobe(input int pos);
    cword_t w;
    w = '0;
    w[pos] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/seq_reset_sync.sv
module seq_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/seq_step_ctr.sv
module seq_step_ctr
  import seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  clear,
  output step_t step_q
);
  step_t step_d;

  always_comb begin
    step_d = step_q;
    if (!hold) begin
      if (clear) step_d = '0;
      else       step_d = step_q + step_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end
endmodule

// File: rtl/seq_ucode_rom.sv
module seq_ucode_rom
  import seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output cword_t            word
);
  step_t      stp;
  op_t        op;
  logic       zf;
  logic       cf;
  logic [2:0] k;      // step index inside the instruction body
  logic       take;

  assign stp = addr[STEP_W-1:0];
  assign op  = addr[STEP_W+OP_W-1:STEP_W];
  assign zf  = addr[STEP_W+OP_W];
  assign cf  = addr[STEP_W+OP_W+1];
  assign k   = stp - 3'd2;

  always_comb begin
    take = 1'b0;
    word = strobe(CB_SRST);  // default: any unused step ends the instruction
    if (stp == 3'd0) begin
      word = strobe(CB_ILAT);
    end else if (stp == 3'd1) begin
      word = strobe(CB_PINC);
    end else if (op[OP_W-1]) begin
      case (k)
        3'd0:    word = strobe(CB_ACMP);
        3'd1:    word = strobe(CB_ADRV) | strobe(CB_LDA);
        default: word = strobe(CB_SRST);
      endcase
    end else begin
      case (op)
        OP_MLA:  if (k == 3'd0) word = strobe(CB_MRD) | strobe(CB_LDA);
        OP_MLB:  if (k == 3'd0) word = strobe(CB_MRD) | strobe(CB_LDB);
        OP_SMA:  if (k == 3'd0) word = strobe(CB_DRA) | strobe(CB_MWR);
        OP_SMB:  if (k == 3'd0) word = strobe(CB_DRB) | strobe(CB_MWR);
        OP_SHOW: if (k == 3'd0) word = strobe(CB_DRA) | strobe(CB_DISP);
        OP_ILA: begin
          if (k == 3'd0)      word = strobe(CB_DBYT) | strobe(CB_LDA);
          else if (k == 3'd1) word = strobe(CB_PINC);
        end
        OP_ILB: begin
          if (k == 3'd0)      word = strobe(CB_DBYT) | strobe(CB_LDB);
          else if (k == 3'd1) word = strobe(CB_PINC);
        end
        OP_JUMP, OP_JZER, OP_JCAR: begin
          take = (op == OP_JUMP) | ((op == OP_JZER) & zf) | ((op == OP_JCAR) & cf);
          if (k == 3'd0)
            word = take ? (strobe(CB_DBYT) | strobe(CB_PJMP)) : strobe(CB_PINC);
        end
        OP_STOP: if (k == 3'd0) word = strobe(CB_HALT);
        default: word = strobe(CB_SRST);
      endcase
    end
  end
endmodule

// File: rtl/ctrl_sequencer.sv
module ctrl_sequencer
  import seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   opcode,
  input  logic         zero_flag,
  input  logic         carry_flag,
  input  logic         halt,
  output logic [15:0]  ctrl_word
);
  logic             rst_sync_n;
  step_t            step_q;
  cword_t           rom_word;
  logic [ADDR_W-1:0] uaddr;
  logic             halted_q;
  logic             halted_d;
  logic             step_hold;

  seq_reset_sync #(.STAGES(2)) i_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign uaddr = {carry_flag, zero_flag, opcode, step_q};

  seq_ucode_rom i_rom (
    .addr (uaddr),
    .word (rom_word)
  );

  assign step_hold = halt | halted_q;

  seq_step_ctr i_step (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hold   (step_hold),
    .clear  (rom_word[CB_SRST]),
    .step_q (step_q)
  );

  // halt latch: set by the halt strobe of the table, cleared by reset only
  always_comb begin
    halted_d = halted_q;
    if (!halt && rom_word[CB_HALT]) halted_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) halted_q <= 1'b0;
    else             halted_q <= halted_d;
  end

  always_comb begin
    if (halt)          ctrl_word = '0;
    else if (halted_q) ctrl_word = strobe(CB_HALT);
    else               ctrl_word = rom_word;
  end
endmodule

// File: rtl/seq_ctrl_checker.sv
module seq_ctrl_checker
  import seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        halt,
  input logic        halted_q,
  input logic [2:0]  step_q,
  input logic [15:0] ctrl_word
);
  // R3: the fetch step drives only the instruction latch
  assert_fetch_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !halted_q && step_q == 3'd0) |-> ctrl_word == 16'h0100);

  // R4: a step-reset word sends the counter back to step 0
  assert_step_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && ctrl_word[15]) |=> step_q == 3'd0);

  // R2: the reserved bit never rises
  assert_reserved_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[14] == 1'b0);

  // R12: the halt input blanks the word and holds the step
  assert_pause_blank_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> ctrl_word == 16'h0000);
  assert_pause_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !ctrl_word[15]) |=> $stable(step_q));

  // R11: once halted, stay halted with a frozen step and a halt-only word
  assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> (halted_q && $stable(step_q)));
  assert_halt_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !halt) |-> ctrl_word == 16'h0800);
endmodule

bind ctrl_sequencer seq_ctrl_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .halt      (halt),
  .halted_q  (halted_q),
  .step_q    (step_q),
  .ctrl_word (ctrl_word)
);

// File: tb/test_ctrl_sequencer.sv
`timescale 1ns/1ps
module test_ctrl_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  opcode;
  logic        zero_flag;
  logic        carry_flag;
  logic        halt;
  logic [15:0] ctrl_word;

  int n_checks = 0;
  int n_bad    = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ctrl_sequencer i_ctrl_sequencer (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag),
    .halt       (halt),
    .ctrl_word  (ctrl_word)
  );

  // bit positions (R2)
  localparam logic [15:0] W_LDA = 16'h0001, W_DRA = 16'h0002, W_LDB = 16'h0004,
                          W_DRB = 16'h0008, W_MWR = 16'h0010, W_MRD = 16'h0020,
                          W_INC = 16'h0040, W_JMP = 16'h0080, W_IF  = 16'h0100,
                          W_DB  = 16'h0200, W_DSP = 16'h0400, W_HLT = 16'h0800,
                          W_CE  = 16'h1000, W_CO  = 16'h2000, W_RS  = 16'h8000;

  function automatic logic [15:0] exp_word(int op, bit z, bit c, int s);
    int k;
    if (s == 0) return W_IF;
    if (s == 1) return W_INC;
    k = s - 2;
    if (op >= 16) begin
      if (k == 0) return W_CE;
      if (k == 1) return W_CO | W_LDA;
      return W_RS;
    end
    if (k > 0 && !(op == 3 || op == 4)) return W_RS;
    case (op)
      1:  return W_MRD | W_LDA;
      2:  return W_MRD | W_LDB;
      3:  return (k == 0) ? (W_DB | W_LDA) : (k == 1) ? W_INC : W_RS;
      4:  return (k == 0) ? (W_DB | W_LDB) : (k == 1) ? W_INC : W_RS;
      5:  return W_DRA | W_MWR;
      6:  return W_DRB | W_MWR;
      7:  return W_DRA | W_DSP;
      8:  return W_DB | W_JMP;
      9:  return z ? (W_DB | W_JMP) : W_INC;
      10: return c ? (W_DB | W_JMP) : W_INC;
      15: return W_HLT;
      default: return W_RS;
    endcase
  endfunction

  function automatic string req_of(int op, int s);
    if (s < 2)  return "R3";
    if (op >= 16) return "R9";
    case (op)
      1, 2, 5, 6, 7: return "R5";
      3, 4:   return "R6";
      8:      return "R7";
      9, 10:  return "R8";
      15:     return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: ctrl_word=%h expected=%h (op=%0d zf=%0b cf=%0b)",
               req, got, exp, opcode, zero_flag, carry_flag);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic start(input int op, input int f);
    rst_n      = 1'b0;
    halt       = 1'b0;
    opcode     = 5'(op);
    zero_flag  = f[0];
    carry_flag = f[1];
    tick();
    check("R1", ctrl_word, W_IF);   // R1 during reset
    rst_n = 1'b1;
    repeat (2) tick();
    check("R1", ctrl_word, W_IF);   // R1 first cycle after release
  endtask

  initial begin
    rst_n = 1'b0; halt = 1'b0; opcode = '0; zero_flag = 1'b0; carry_flag = 1'b0;
    repeat (3) tick();

    // sweep every opcode under every flag combination
    for (int op = 0; op < 32; op++) begin
      for (int f = 0; f < 4; f++) begin
        start(op, f);
        for (int s = 0; s < 8; s++) begin
          logic [15:0] e;
          e = exp_word(op, f[0], f[1], s);
          check(req_of(op, s), ctrl_word, e);
          check("R2", {15'd0, ctrl_word[14]}, 16'd0);
          if (e[15]) begin
            tick();
            check("R4", ctrl_word, W_IF);
            break;
          end
          if (e[11]) begin
            for (int h = 0; h < 3; h++) begin
              tick();
              check("R11", ctrl_word, W_HLT);
            end
            break;
          end
          tick();
        end
      end
    end

    // R11: frozen after halt strobe regardless of opcode and flags
    start(15, 0);
    repeat (3) tick();
    opcode = 5'd16; zero_flag = 1'b1; carry_flag = 1'b1;
    #1 check("R11", ctrl_word, W_HLT);
    for (int h = 0; h < 4; h++) begin
      tick();
      opcode = 5'(h + 1);
      #1 check("R11", ctrl_word, W_HLT);
    end
    rst_n = 1'b0; opcode = 5'd0;
    #1 check("R1", ctrl_word, W_IF);
    rst_n = 1'b1;
    repeat (2) tick();

    // R12: pause a literal load at step 2, then resume there
    start(3, 0);
    tick(); tick();
    check("R6", ctrl_word, W_DB | W_LDA);
    halt = 1'b1;
    #1 check("R12", ctrl_word, 16'h0000);
    for (int h = 0; h < 3; h++) begin
      tick();
      check("R12", ctrl_word, 16'h0000);
    end
    halt = 1'b0;
    #1 check("R12", ctrl_word, W_DB | W_LDA);
    tick(); check("R12", ctrl_word, W_INC);
    tick(); check("R12", ctrl_word, W_RS);
    tick(); check("R4", ctrl_word, W_IF);

    // R12: pause during fetch step 1 of an ALU op
    start(17, 0);
    tick();
    halt = 1'b1;
    tick(); tick();
    halt = 1'b0;
    #1 check("R12", ctrl_word, W_INC);
    tick(); check("R9", ctrl_word, W_CE);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule